// File: doc/BRIEF.md
# Recirculating Serial Word Store

This block models a bit-serial store built from circulating lines. Line 0 is a short fast line of 16 words. Lines 1 to 15 are long lines of 256 words each. Every word is 22 bits wide. A shared timing chain sets which slot is at the read head. A bit counter steps through the 24 bit times of one slot: 22 data bits, least significant first, then 2 gap bits. A sector counter names the slot at the head of the long lines. On the fast line the slot at the head is that count modulo 16.

A requester presents a line number, a word address, a direction and, for a write, the data. It uses a valid/ready handshake. The block waits until the addressed slot comes round to the head. A read streams the word out one bit per cycle with a strobe. A write replaces the word as its slot passes. Both end with a one-cycle done pulse. Because of this, access latency depends on where the head stands. A helper also forms the next instruction address. With the sequencing flag clear, it is the current address plus one. With the flag set, it is the slot now at the head.

Reset zeroes the counters. The block then makes one full revolution in which every slot of every line is overwritten with zero. Only after that does it take requests.

FSM states: CLEAR (zeroing revolution), IDLE (ready), WAIT (the addressed slot is not yet at the head), XFER (the slot is at the head and the transfer is running). Transitions: CLEAR to IDLE at the end of slot 255. IDLE to XFER when a request is taken in the last bit time before its slot. IDLE to WAIT on any other request. WAIT to XFER in the last bit time before the slot. XFER to IDLE at the slot's last bit time, together with done.

Top module: `delay_line_store`

## Requirements
- R1: After reset the head is at sector 0, bit 0, and req_ready is low for exactly 256×24 = 6144 cycles of zeroing. The head is back at sector 0, bit 0 when ready first rises.
- R2: head_bit counts 0 to 23 and wraps. head_sector steps by one, modulo 256, only when head_bit wraps from 23.
- R3: A word never written since reset reads as zero.
- R4: A read raises rd_strobe for exactly 22 cycles, at head_bit 0 to 21 of the addressed slot. rd_bit carries data bit k at head_bit k, least significant bit first. done pulses for one cycle at head_bit 23 of that slot.
- R5: The transfer uses the first slot whose bit 0 comes after the acceptance cycle and whose index matches the address. The wait is never more than 256 slots.
- R6: For line 0 only the low 4 address bits count. The slot matches when head_sector modulo 16 equals them, so addresses that differ only in bits 7:4 reach the same word.
- R7: A write gives no strobe and pulses done at head_bit 23 of the addressed slot. Later reads of that word return the new data. Other slots and other lines are left unchanged.
- R8: req_ready is low from the cycle after acceptance until the done cycle, and high in the cycle after done.
- R9: next_addr equals (cur_addr+1) mod 256 when seq_flag is 0, and equals head_sector when seq_flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_line | input | 4 | Line number, 0 is the fast line |
| req_addr | input | 8 | Word address within the line |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 22 | Word to write |
| rd_bit | output | 1 | Serial read data, LSB first |
| rd_strobe | output | 1 | rd_bit is valid |
| done | output | 1 | Transfer complete |
| head_sector | output | 8 | Slot index at the head of the long lines |
| head_bit | output | 5 | Bit time within the current slot |
| seq_flag | input | 1 | Sequencing flag of the current instruction |
| cur_addr | input | 8 | Address of the current instruction |
| next_addr | output | 8 | Next instruction address |

## Verification
A wrong timing count shows up in head_bit or head_sector within one slot. It also moves the first strobe of every access away from the cycle the bench predicts from the head position at acceptance. A wrong latched line, address or state shows in the same access. The symptom is a wrong strobe count, a done pulse in the wrong cycle, or data taken from a neighbouring slot. A write that goes to the wrong slot shows only at the next read of that slot or of its neighbours. For that reason each write is followed by reads of the target and of an adjacent slot and line.

// File: rtl/dls_pkg.sv
package dls_pkg;
    localparam int WORD_BITS  = 22;
    localparam int GAP_BITS   = 2;
    localparam int SLOT_BITS  = WORD_BITS + GAP_BITS;
    localparam int LONG_DEPTH = 256;
    localparam int FAST_DEPTH = 16;
    localparam int NUM_LINES  = 16;
    localparam int SEC_W      = $clog2(LONG_DEPTH);
    localparam int BIT_W      = $clog2(SLOT_BITS);
    localparam int LINE_W     = $clog2(NUM_LINES);
    localparam int FAST_AW    = $clog2(FAST_DEPTH);
    localparam int REV_CYCLES = LONG_DEPTH * SLOT_BITS;
    localparam int WAIT_W     = $clog2(REV_CYCLES) + 1;

    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_WAIT,
        ST_XFER
    } dls_state_e;
endpackage

// File: rtl/dls_timing.sv
module dls_timing
    import dls_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [SEC_W-1:0] sector_o,
    output logic [BIT_W-1:0] bit_o,
    output logic             slot_end_o
);
    logic [SEC_W-1:0] sector_q;
    logic [BIT_W-1:0] bit_q;

    assign slot_end_o = (bit_q == BIT_W'(SLOT_BITS - 1));
    assign sector_o   = sector_q;
    assign bit_o      = bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sector_q <= '0;
            bit_q    <= '0;
        end else if (slot_end_o) begin
            bit_q    <= '0;
            sector_q <= sector_q + 1'b1;
        end else begin
            bit_q    <= bit_q + 1'b1;
        end
    end

    p_bit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= BIT_W'(SLOT_BITS - 1));
    p_sector_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end_o |=> (sector_q == $past(sector_q) + 1'b1) && (bit_q == '0));
    p_sector_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end_o |=> $stable(sector_q));
endmodule

// File: rtl/dls_line.sv
module dls_line
    import dls_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic [AW-1:0]        slot_i,
    input  logic                 we_i,
    input  logic [WORD_BITS-1:0] wdata_i,
    output logic [WORD_BITS-1:0] rdata_o
);
    logic [WORD_BITS-1:0] cells [DEPTH];

    assign rdata_o = cells[slot_i];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[slot_i] <= wdata_i;
        end
    end
endmodule

// File: rtl/dls_next_addr.sv
module dls_next_addr
    import dls_pkg::*;
(
    input  logic             seq_flag_i,
    input  logic [SEC_W-1:0] cur_i,
    input  logic [SEC_W-1:0] sector_i,
    output logic [SEC_W-1:0] next_o
);
    always_comb begin
        if (seq_flag_i) begin
            next_o = sector_i;
        end else begin
            next_o = cur_i + 1'b1;
        end
    end
endmodule

// File: rtl/delay_line_store.sv
module delay_line_store
    import dls_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [LINE_W-1:0]    req_line,
    input  logic [SEC_W-1:0]     req_addr,
    input  logic                 req_write,
    input  logic [WORD_BITS-1:0] req_wdata,
    output logic                 rd_bit,
    output logic                 rd_strobe,
    output logic                 done,
    output logic [SEC_W-1:0]     head_sector,
    output logic [BIT_W-1:0]     head_bit,
    input  logic                 seq_flag,
    input  logic [SEC_W-1:0]     cur_addr,
    output logic [SEC_W-1:0]     next_addr
);
    dls_state_e state_q, state_d;
    logic [LINE_W-1:0]    line_q;
    logic [SEC_W-1:0]     addr_q;
    logic                 wr_q;
    logic [WORD_BITS-1:0] wdata_q;
    logic                 slot_end;
    logic [SEC_W-1:0]     sec_next;
    logic [WORD_BITS-1:0] rd_word;
    logic [WORD_BITS-1:0] rd_shift;
    logic [WORD_BITS-1:0] line_wdata;
    logic [NUM_LINES-1:0] line_we;
    logic [WORD_BITS-1:0] line_rdata [NUM_LINES];
    logic                 accept;

    function automatic logic slot_hit(input logic [LINE_W-1:0] ln,
                                      input logic [SEC_W-1:0]  ad,
                                      input logic [SEC_W-1:0]  sc);
        if (ln == '0) begin
            return ad[FAST_AW-1:0] == sc[FAST_AW-1:0];
        end
        return ad == sc;
    endfunction

    dls_timing u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .sector_o   (head_sector),
        .bit_o      (head_bit),
        .slot_end_o (slot_end)
    );

    dls_next_addr u_next (
        .seq_flag_i (seq_flag),
        .cur_i      (cur_addr),
        .sector_i   (head_sector),
        .next_o     (next_addr)
    );

    assign sec_next = head_sector + 1'b1;
    assign accept   = (state_q == ST_IDLE) && req_valid;

    // One storage line per generate slot; line 0 is the short fast line.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int DEPTH_I = (i == 0) ? FAST_DEPTH : LONG_DEPTH;
        localparam int AW_I    = $clog2(DEPTH_I);
        dls_line #(.DEPTH(DEPTH_I)) u_line (
            .clk     (clk),
            .slot_i  (head_sector[AW_I-1:0]),
            .we_i    (line_we[i]),
            .wdata_i (line_wdata),
            .rdata_o (line_rdata[i])
        );
        assign line_we[i] = slot_end &&
                            ((state_q == ST_CLEAR) ||
                             ((state_q == ST_XFER) && wr_q && (line_q == LINE_W'(i))));
    end

    assign rd_word  = line_rdata[line_q];
    assign rd_shift = rd_word >> head_bit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            line_q  <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                line_q  <= req_line;
                addr_q  <= req_addr;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (slot_end && (head_sector == SEC_W'(LONG_DEPTH - 1))) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (req_valid) begin
                    if (slot_end && slot_hit(req_line, req_addr, sec_next)) begin
                        state_d = ST_XFER;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (slot_end && slot_hit(line_q, addr_q, sec_next)) begin
                    state_d = ST_XFER;
                end
            end
            ST_XFER: begin
                if (slot_end) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rd_strobe  = (state_q == ST_XFER) && !wr_q &&
                     (head_bit < BIT_W'(WORD_BITS));
        rd_bit     = rd_strobe && rd_shift[0];
        done       = (state_q == ST_XFER) && slot_end;
        line_wdata = (state_q == ST_CLEAR) ? '0 : wdata_q;
    end

    // Checker state: cycles spent waiting for the head.
    logic [WAIT_W-1:0] wait_cnt;
    logic              in_xfer;
    assign in_xfer = (state_q == ST_XFER);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (state_q == ST_WAIT) begin
            wait_cnt <= wait_cnt + 1'b1;
        end else begin
            wait_cnt <= '0;
        end
    end

    p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= WAIT_W'(REV_CYCLES));
    p_start_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_xfer) |-> (head_bit == '0) && slot_hit(line_q, addr_q, head_sector));
    p_done_then_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    p_last_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_q) |-> $past(rd_strobe, 2) && !$past(rd_strobe));
    p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_xfer && wr_q) |-> !rd_strobe);
endmodule

// File: tb/sim_delay_line_store.sv
module sim_delay_line_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_line = '0;
    logic [7:0]  req_addr = '0;
    logic        req_write = 1'b0;
    logic [21:0] req_wdata = '0;
    logic        rd_bit, rd_strobe, done;
    logic [7:0]  head_sector;
    logic [4:0]  head_bit;
    logic        seq_flag = 1'b0;
    logic [7:0]  cur_addr = '0;
    logic [7:0]  next_addr;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    delay_line_store u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_line(req_line), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .rd_bit(rd_bit), .rd_strobe(rd_strobe), .done(done),
        .head_sector(head_sector), .head_bit(head_bit), .seq_flag(seq_flag),
        .cur_addr(cur_addr), .next_addr(next_addr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access. at_bit>=0 waits for that head_bit before driving;
    // rel>=0 replaces the address by head_sector+rel.
    task automatic access(input int line, input int addr, input bit wr,
                          input logic [21:0] wd, input int at_bit, input int rel,
                          output logic [21:0] data);
        int b, s, n0, n, first, cnt, ndone, a;
        data = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (at_bit >= 0) while (head_bit != at_bit) @(negedge clk);
        b = head_bit;
        s = head_sector;
        a = (rel >= 0) ? (s + rel) % 256 : addr;
        req_valid = 1'b1; req_line = line[3:0]; req_addr = a[7:0];
        req_write = wr; req_wdata = wd;
        n0 = -1;
        for (int j = 1; j <= 256; j++) begin
            int sec;
            sec = (s + j) % 256;
            if (n0 < 0 && ((line == 0) ? ((sec % 16) == (a % 16)) : (sec == a)))
                n0 = (24 - b) + 24 * (j - 1);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8 busy after accept", req_ready, 0);
        n = 1; first = -1; cnt = 0; ndone = -1;
        while (ndone < 0 && n < 7000) begin
            if (rd_strobe) begin
                if (first < 0) first = n;
                if (cnt < 22) data[cnt] = rd_bit;
                cnt++;
            end
            if (done) ndone = n;
            else begin
                @(negedge clk);
                n++;
            end
        end
        if (!wr) begin
            chk(first == n0, "R5 first strobe cycle", first, n0);
            chk(cnt == 22, "R4 strobe count", cnt, 22);
        end else begin
            chk(cnt == 0, "R7 no strobe on write", cnt, 0);
        end
        chk(ndone == n0 + 23, "R4 done cycle", ndone, n0 + 23);
        @(negedge clk);
        chk(req_ready, "R8 ready after done", req_ready, 1);
    endtask

    task automatic t_reset();
        int n;
        chk(head_sector == 0 && head_bit == 0, "R1 head at reset", {head_sector, head_bit}, 0);
        chk(!req_ready, "R1 not ready at reset", req_ready, 0);
        rst_n = 1'b1;
        n = 0;
        while (!req_ready && n < 10000) begin
            @(negedge clk);
            n++;
        end
        chk(n == 6144, "R1 zeroing length", n, 6144);
        chk(head_sector == 0 && head_bit == 0, "R1 head after zeroing", {head_sector, head_bit}, 0);
    endtask

    task automatic t_counter();
        int pb, ps, bad;
        bad = 0;
        pb = head_bit; ps = head_sector;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (head_bit != (pb + 1) % 24) bad++;
            if (head_sector != ((pb == 23) ? (ps + 1) % 256 : ps)) bad++;
            pb = head_bit; ps = head_sector;
        end
        chk(bad == 0, "R2 counter progression", bad, 0);
    endtask

    task automatic t_cleared();
        logic [21:0] d;
        access(5, 77, 0, '0, -1, -1, d);
        chk(d == 0, "R3 long line zero", d, 0);
        access(0, 3, 0, '0, -1, -1, d);
        chk(d == 0, "R3 fast line zero", d, 0);
    endtask

    task automatic t_write_read();
        logic [21:0] d;
        access(3, 5, 1, 22'h2A5A5B, -1, -1, d);
        access(3, 5, 0, '0, -1, -1, d);
        chk(d == 22'h2A5A5B, "R7 R4 readback LSB first", d, 22'h2A5A5B);
        access(3, 6, 0, '0, -1, -1, d);
        chk(d == 0, "R7 neighbour slot unchanged", d, 0);
        access(4, 5, 0, '0, -1, -1, d);
        chk(d == 0, "R7 neighbour line unchanged", d, 0);
    endtask

    task automatic t_fast();
        logic [21:0] d;
        access(0, 8'h25, 1, 22'h155551, -1, -1, d);
        access(0, 8'h05, 0, '0, -1, -1, d);
        chk(d == 22'h155551, "R6 fast line upper bits ignored", d, 22'h155551);
        access(1, 5, 0, '0, -1, -1, d);
        chk(d == 0, "R6 long line not aliased", d, 0);
    endtask

    task automatic t_overwrite();
        logic [21:0] d;
        access(15, 255, 1, 22'h3FFFFF, -1, -1, d);
        access(15, 255, 1, 22'h000081, -1, -1, d);
        access(15, 255, 0, '0, -1, -1, d);
        chk(d == 22'h000081, "R7 overwrite", d, 22'h000081);
        access(15, 0, 0, '0, -1, -1, d);
        chk(d == 0, "R7 wrap neighbour unchanged", d, 0);
    endtask

    task automatic t_timing_edges();
        logic [21:0] d;
        access(2, 0, 0, '0, 23, 1, d);
        chk(d == 0, "R5 immediate slot", d, 0);
        access(2, 0, 0, '0, 0, 0, d);
        chk(d == 0, "R5 full revolution wait", d, 0);
        access(7, 0, 1, 22'h0ABCDE, 23, 0, d);
        access(7, 0, 0, '0, 12, 40, d);
    endtask

    task automatic t_next_addr();
        @(negedge clk);
        seq_flag = 1'b0; cur_addr = 8'd41; #1;
        chk(next_addr == 8'd42, "R9 sequential", next_addr, 42);
        cur_addr = 8'd255; #1;
        chk(next_addr == 8'd0, "R9 sequential wrap", next_addr, 0);
        seq_flag = 1'b1; #1;
        chk(next_addr == head_sector, "R9 head slot", next_addr, head_sector);
        repeat (30) @(negedge clk);
        #1;
        chk(next_addr == head_sector, "R9 head slot later", next_addr, head_sector);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_counter();
        t_cleared();
        t_write_read();
        t_fast();
        t_overwrite();
        t_timing_edges();
        t_next_addr();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R5 watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule